// File: doc/BRIEF.md
# Dual-Rail Precharge Logic Datapath

This block evaluates a small bitwise function, z = (a AND b) OR (NOT c), on W-bit operands and keeps the result in a register. Both the function and the register are built so that the amount of switching is the same for every data value. Each logical bit travels on two wires, a true rail and a false rail. A 1 is encoded as (true=1, false=0) and a 0 as (true=0, false=1). The pair (0,0) is the precharge state. The pair (1,1) is illegal.

The clock sets the two phases. While clk is high, every rail pair in the network is held at (0,0). While clk is low, each pair evaluates and exactly one of its two rails rises. The single-rail operands enter through converters. These give (0,0) while clk is high and (d, not d) while clk is low. The AND and OR gates use only non-inverting logic on the rails. The NOT of c costs no gate: its true and false rails are swapped. The register captures the evaluated pair at the end of each evaluate phase. It presents that value, precharged in the same way, during the next evaluate phase. An internal monitor watches every rail pair and raises a sticky error flag on any violation of the one-hot rule.

Reset is asynchronous and active low, with a synchronous release two clock edges later. While reset is in effect, the register holds logic 0 and the error flag is cleared.

Top module: `dr_datapath`

## Requirements
- R1: During the evaluate phase (clk low), for every bit i, exactly one of y_t[i] and y_f[i] is 1, and y_t equals (a_in AND b_in) OR (NOT c_in) for the operands held during that phase. The encoding is: true rail high means 1, false rail high means 0.
- R2: During the precharge phase (clk high), all of y_t, y_f, q_t and q_f are 0.
- R3: During every evaluate phase, the number of output rails at 1 is exactly 2*W (one per pair on y and q), whatever the operand values.
- R4: During the evaluate phase of a cycle, q_t and q_f give the dual-rail value that y_t and y_f held in the evaluate phase of the previous cycle.
- R5: While rst_n is low, and for the two clock edges after it is released, q decodes to all zeros (q_f all ones during evaluate) and rail_err is 0.
- R6: The monitor sets its error output as soon as any monitored pair shows (1,1), in either phase. The error stays set until reset.
- R7: The monitor sets its error output at the clock edge that ends an evaluate phase in which some monitored pair never left (0,0). The error is not raised before that edge.
- R8: With legal operands and a correct rail network, rail_err remains 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Phase clock: high = precharge, low = evaluate |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| a_in | input | W | First single-rail operand, held through the evaluate phase |
| b_in | input | W | Second single-rail operand |
| c_in | input | W | Third single-rail operand (used inverted) |
| y_t | output | W | True rails of the combinational result |
| y_f | output | W | False rails of the combinational result |
| q_t | output | W | True rails of the registered result |
| q_f | output | W | False rails of the registered result |
| rail_err | output | 1 | Sticky flag: a monitored pair broke the one-hot rule |

## Verification
The function is first driven with hand-picked operands: all zeros, all ones, alternating bit patterns and inverted c. These separate the AND from the OR and show whether the rail swap for NOT c is correct. A sweep over every combination of the three operands then shows that the rail-rise count and the precharge-to-zero behaviour hold for every value. This sweep finds any gate whose cost depends on the data. The monitor is also exercised on its own with a clashing pair, an incomplete pair and legal pairs. These show apart the immediate clash detection, the end-of-evaluate completion check, the sticky hold and the clear on reset.

// File: rtl/dr_pkg.sv
package dr_pkg;

  // One logical bit as a rail pair; (0,0) is the precharge state.
  typedef struct packed {
    logic t;
    logic f;
  } dpair_t;

  typedef enum logic {
    GATE_AND = 1'b0,
    GATE_OR  = 1'b1
  } gate_kind_e;

  // Logical inversion: exchange the rails, no inverting gate involved.
  function automatic dpair_t dr_swap(input dpair_t p);
    dpair_t r;
    r.t = p.f;
    r.f = p.t;
    return r;
  endfunction

endpackage

// File: rtl/dr_enc.sv
module dr_enc
  import dr_pkg::*;
#(
  parameter int W = 4
) (
  input  logic           clk,
  input  logic [W-1:0]   d,
  output dpair_t [W-1:0] p
);

  // Precharge while clk is high, one rail rises while clk is low.
  for (genvar i = 0; i < W; i++) begin : g_bit
    assign p[i].t = d[i] & ~clk;
    assign p[i].f = ~d[i] & ~clk;
  end

endmodule

// File: rtl/dr_gate.sv
module dr_gate
  import dr_pkg::*;
#(
  parameter int         W    = 4,
  parameter gate_kind_e KIND = GATE_AND
) (
  input  dpair_t [W-1:0] x_p,
  input  dpair_t [W-1:0] w_p,
  output dpair_t [W-1:0] z_p
);

  if (KIND == GATE_AND) begin : g_and
    for (genvar i = 0; i < W; i++) begin : g_bit
      assign z_p[i].t = x_p[i].t & w_p[i].t;
      assign z_p[i].f = x_p[i].f | w_p[i].f;
    end
  end else begin : g_or
    for (genvar i = 0; i < W; i++) begin : g_bit
      assign z_p[i].t = x_p[i].t | w_p[i].t;
      assign z_p[i].f = x_p[i].f & w_p[i].f;
    end
  end

endmodule

// File: rtl/dr_reg.sv
module dr_reg
  import dr_pkg::*;
#(
  parameter int W = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  dpair_t [W-1:0] d,
  output dpair_t [W-1:0] q
);

  for (genvar i = 0; i < W; i++) begin : g_bit
    logic m_t, m_f;
    logic s_t, s_f;
    logic s_t_nxt, s_f_nxt;
    logic pair_done;

    assign pair_done = d[i].t ^ d[i].f;

    // Master: follows the pair only once it has evaluated, so the
    // precharge wave at the end of the phase never overwrites it.
    always_latch begin
      if (!clk && pair_done) begin
        m_t <= d[i].t;
        m_f <= d[i].f;
      end
    end

    always_comb begin
      s_t_nxt = m_t;
      s_f_nxt = m_f;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        s_t <= 1'b0;
        s_f <= 1'b1;
      end else begin
        s_t <= s_t_nxt;
        s_f <= s_f_nxt;
      end
    end

    assign q[i].t = s_t & ~clk;
    assign q[i].f = s_f & ~clk;
  end

endmodule

// File: rtl/dr_mon.sv
module dr_mon #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] pt,
  input  logic [N-1:0] pf,
  output logic         err
);

  logic clash;
  logic complete;
  logic phase_q;
  logic stamp;
  logic clash_q;
  logic err_q;
  logic err_nxt;

  assign clash    = |(pt & pf);
  assign complete = &(pt | pf);

  // Records the cycle parity in which all pairs finished evaluating.
  always_latch begin
    if (!clk && complete) begin
      stamp <= phase_q;
    end
  end

  // A clash is flagged at once and held until reset.
  always_latch begin
    if (!rst_n) begin
      clash_q <= 1'b0;
    end else if (clash) begin
      clash_q <= 1'b1;
    end
  end

  always_comb begin
    err_nxt = err_q | (stamp != phase_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      phase_q <= ~phase_q;
      err_q   <= err_nxt;
    end
  end

  assign err = err_q | clash_q;

endmodule

// File: rtl/dr_datapath.sv
module dr_datapath
  import dr_pkg::*;
#(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] a_in,
  input  logic [W-1:0] b_in,
  input  logic [W-1:0] c_in,
  output logic [W-1:0] y_t,
  output logic [W-1:0] y_f,
  output logic [W-1:0] q_t,
  output logic [W-1:0] q_f,
  output logic         rail_err
);

  localparam int NGROUP = 6;
  localparam int NPAIR  = NGROUP * W;

  logic [1:0] rst_pipe;
  logic [1:0] rst_pipe_nxt;
  logic       rst_s;

  always_comb begin
    rst_pipe_nxt = {rst_pipe[0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe <= 2'b00;
    end else begin
      rst_pipe <= rst_pipe_nxt;
    end
  end

  assign rst_s = rst_pipe[1];

  dpair_t [W-1:0] a_p, b_p, c_p, ab_p, nc_p, y_p, q_p;

  dr_enc #(.W(W)) u_enc_a (.clk(clk), .d(a_in), .p(a_p));
  dr_enc #(.W(W)) u_enc_b (.clk(clk), .d(b_in), .p(b_p));
  dr_enc #(.W(W)) u_enc_c (.clk(clk), .d(c_in), .p(c_p));

  dr_gate #(.W(W), .KIND(GATE_AND)) u_and (.x_p(a_p), .w_p(b_p), .z_p(ab_p));

  for (genvar i = 0; i < W; i++) begin : g_inv
    assign nc_p[i] = dr_swap(c_p[i]);
  end

  dr_gate #(.W(W), .KIND(GATE_OR)) u_or (.x_p(ab_p), .w_p(nc_p), .z_p(y_p));

  dr_reg #(.W(W)) u_reg (.clk(clk), .rst_n(rst_s), .d(y_p), .q(q_p));

  dpair_t [NPAIR-1:0] all_p;
  logic   [NPAIR-1:0] mon_t, mon_f;

  assign all_p = {a_p, b_p, c_p, ab_p, y_p, q_p};

  for (genvar k = 0; k < NPAIR; k++) begin : g_mon
    assign mon_t[k] = all_p[k].t;
    assign mon_f[k] = all_p[k].f;
  end

  dr_mon #(.N(NPAIR)) u_mon (
    .clk  (clk),
    .rst_n(rst_s),
    .pt   (mon_t),
    .pf   (mon_f),
    .err  (rail_err)
  );

  for (genvar i = 0; i < W; i++) begin : g_out
    assign y_t[i] = y_p[i].t;
    assign y_f[i] = y_p[i].f;
    assign q_t[i] = q_p[i].t;
    assign q_f[i] = q_p[i].f;
  end

endmodule

// File: rtl/dr_datapath_sva.sv
module dr_datapath_sva #(
  parameter int W = 4
) (
  input logic         clk,
  input logic         rst_s,
  input logic [W-1:0] a_in,
  input logic [W-1:0] b_in,
  input logic [W-1:0] c_in,
  input logic [W-1:0] y_t,
  input logic [W-1:0] y_f,
  input logic [W-1:0] q_t,
  input logic [W-1:0] q_f,
  input logic         rail_err
);

  assert_eval_onehot_R1: assert property (@(posedge clk) disable iff (!rst_s)
    (&(y_t ^ y_f)) && (&(q_t ^ q_f)));

  assert_eval_value_R1: assert property (@(posedge clk) disable iff (!rst_s)
    y_t == ((a_in & b_in) | ~c_in));

  assert_precharge_zero_R2: assert property (@(negedge clk) disable iff (!rst_s)
    (y_t | y_f | q_t | q_f) == '0);

  assert_rise_count_R3: assert property (@(posedge clk) disable iff (!rst_s)
    $countones({y_t, y_f, q_t, q_f}) == 2 * W);

  assert_reg_follows_R4: assert property (@(posedge clk) disable iff (!rst_s)
    $past(rst_s) |-> (q_t == $past(y_t)) && (q_f == $past(y_f)));

  assert_no_rail_err_R8: assert property (@(posedge clk) disable iff (!rst_s)
    !rail_err);

endmodule

bind dr_datapath dr_datapath_sva #(.W(W)) u_sva (
  .clk     (clk),
  .rst_s   (rst_s),
  .a_in    (a_in),
  .b_in    (b_in),
  .c_in    (c_in),
  .y_t     (y_t),
  .y_f     (y_f),
  .q_t     (q_t),
  .q_f     (q_f),
  .rail_err(rail_err)
);

// File: tb/dr_datapath_bench.sv
module dr_datapath_bench;

  localparam int W      = 4;
  localparam int PERIOD = 10;
  localparam int HALF   = PERIOD / 2;
  localparam int QVALID = 6;  // first cycle whose q carries real data

  logic         clk;
  logic         rst_n;
  logic [W-1:0] a, b, c;
  logic [W-1:0] y_t, y_f, q_t, q_f;
  logic         rail_err;

  logic         mon_rst_n;
  logic [1:0]   mtv, mfv;
  logic [1:0]   mt, mf;
  logic         merr;

  int           n_cmp;
  int           n_bad;
  int           cyc;
  logic [W-1:0] prev_z;
  bit           done;

  dr_datapath #(.W(W)) u_dr_datapath (
    .clk(clk), .rst_n(rst_n), .a_in(a), .b_in(b), .c_in(c),
    .y_t(y_t), .y_f(y_f), .q_t(q_t), .q_f(q_f), .rail_err(rail_err)
  );

  assign mt = mtv & {2{~clk}};
  assign mf = mfv & {2{~clk}};

  dr_mon #(.N(2)) u_mon (.clk(clk), .rst_n(mon_rst_n), .pt(mt), .pf(mf), .err(merr));

  initial clk = 1'b1;
  always #(HALF) clk = ~clk;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Entered 1 time unit into the precharge phase.
  task automatic step(input logic [W-1:0] ta, input logic [W-1:0] tb,
                      input logic [W-1:0] tc);
    logic [W-1:0] z;
    int hi;
    a = ta; b = tb; c = tc;
    z = (ta & tb) | ~tc;
    #2;
    hi = $countones({y_t, y_f, q_t, q_f});
    chk(hi == 0, "R2", "rails high in precharge", hi, 0);
    #(HALF);
    chk((y_t ^ y_f) == {W{1'b1}}, "R1", "pair one-hot", y_t ^ y_f, {W{1'b1}});
    chk(y_t == z, "R1", "decoded result", y_t, z);
    hi = $countones({y_t, y_f, q_t, q_f});
    chk(hi == 2 * W, "R3", "rising rails in evaluate", hi, 2 * W);
    if (cyc < QVALID) begin
      chk(q_t == '0 && q_f == {W{1'b1}}, "R5", "register in reset",
          {q_t, q_f}, {{W{1'b0}}, {W{1'b1}}});
      chk(rail_err == 1'b0, "R5", "error during reset", rail_err, 0);
    end else begin
      chk(q_t == prev_z && q_f == ~prev_z, "R4", "registered result",
          {q_t, q_f}, {prev_z, ~prev_z});
      chk(rail_err == 1'b0, "R8", "error in normal run", rail_err, 0);
    end
    prev_z = z;
    cyc++;
    #(PERIOD - HALF - 2);
  endtask

  task automatic mstep(input logic [1:0] tv, input logic [1:0] fv, input logic rv,
                       input logic e_pre, input logic e_eval, input string req);
    mtv = tv; mfv = fv; mon_rst_n = rv;
    #2;
    chk(merr == e_pre, req, "monitor flag in precharge", merr, e_pre);
    #(HALF);
    chk(merr == e_eval, req, "monitor flag in evaluate", merr, e_eval);
    #(PERIOD - HALF - 2);
  endtask

  initial begin
    n_cmp = 0; n_bad = 0; cyc = 0; prev_z = '0; done = 0;
    rst_n = 1'b1; mon_rst_n = 1'b1;
    a = '0; b = '0; c = '0; mtv = 2'b00; mfv = 2'b00;
    #1;
    rst_n = 1'b0; mon_rst_n = 1'b0;
    // R5: reset held for three cycles, then released
    step('0, '0, '0);
    step({W{1'b1}}, {W{1'b1}}, {W{1'b1}});
    step('0, '0, {W{1'b1}});
    rst_n = 1'b1;
    step(4'h5, 4'hF, 4'hF);
    step(4'hA, 4'hA, 4'h5);
    step(4'h3, 4'hC, 4'hF);
    // R1 R3 R4: directed patterns separating AND, OR and the swap
    step('0, '0, '0);
    step({W{1'b1}}, {W{1'b1}}, {W{1'b1}});
    step('0, '0, {W{1'b1}});
    step(4'h5, 4'hF, 4'hF);
    step(4'hF, 4'h5, 4'hA);
    step(4'h9, 4'h6, 4'hE);
    // R1 R2 R3 R4 R8: every operand combination
    for (int v = 0; v < (1 << (3 * W)); v++) begin
      step(v[W-1:0], v[2*W-1:W], v[3*W-1:2*W]);
    end

    // Monitor on its own: legal pairs are (t,f) = (1,0) or (0,1)
    mstep(2'b01, 2'b10, 1'b1, 1'b0, 1'b0, "R8");
    mstep(2'b10, 2'b01, 1'b1, 1'b0, 1'b0, "R8");
    // R6: pair 0 is (1,1) during evaluate
    mstep(2'b11, 2'b01, 1'b1, 1'b0, 1'b1, "R6");
    mstep(2'b01, 2'b10, 1'b1, 1'b1, 1'b1, "R6");
    mstep(2'b01, 2'b10, 1'b0, 1'b0, 1'b0, "R6");
    mstep(2'b01, 2'b10, 1'b1, 1'b0, 1'b0, "R6");
    // R7: pair 0 stays (0,0) for a whole evaluate phase
    mstep(2'b10, 2'b00, 1'b1, 1'b0, 1'b0, "R7");
    mstep(2'b01, 2'b10, 1'b1, 1'b1, 1'b1, "R7");

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(PERIOD * 200000);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule